// File: doc/BRIEF.md
# Chained Double-Buffer DMA Channel

This block is one DMA channel that moves 32-bit words between a device port and a memory request port. Software describes the active segment with a current-address register and an end-address register. It may also describe a follow-on segment with a second pair of registers. The channel moves one word for each device request. It issues the memory access at the current address, then steps that address by one word. When the current address reaches the end address, the active segment is finished.

At the end of a segment, the channel sets its completion flag. If single-shot mode is off, it loads the follow-on pair into the active pair and keeps running. This lets software refill the follow-on pair while the other buffer drains. If single-shot mode is on, the channel stops. Each segment end also records a snapshot of all four pointers in read-only shadow registers, so an interrupted transfer can be restarted.

Control writes are one-shot commands: set, clear or reset. They are kept apart from the status bits that are read back. A memory error response halts the channel, so does a segment longer than the size limit. After either fault, the pointers stay frozen until a reset command.

Top module: `seg_dma_channel`

## Requirements
- R1: After rst_n is released, reg_rdata is 0 for every register index 0 to 8, and mem_req and dev_ack are low.
- R2: A write to index 0 acts on bits 16, 17 and 18 as follows. Bit 16 set turns running on and bit 17 set turns single-shot on; a zero in either has no effect. Bit 18 is copied into the direction flag on every such write: 1 means device-to-memory (mem_we high) and 0 means memory-to-device. Reading index 0 returns running in bit 24, single-shot in bit 25, direction in bit 26, done in bit 27 and fault in bit 28, with every other bit 0.
- R3: The register indices are 1 current address, 2 end address, 3 follow-on start, 4 follow-on end, and 5 to 8 the read-only shadows of indices 1 to 4. Writes to indices 1 and 3 clear the low 2 address bits, and writes to indices 2 and 4 clear the low 4 bits. Writes to indices 5 to 8 have no effect.
- R4: While running, with no access outstanding, the current address equal to the end address and single-shot on, the channel sets done and stops running without a memory request. An empty segment therefore ends with no transfer.
- R5: In one transfer the channel, while running and idle with dev_req high, raises mem_req with mem_addr set to the current address and mem_we set to the direction. It holds both until mem_rsp. On a response without mem_err, dev_ack is high for that cycle, data passes between the two ports, and the current address rises by 4.
- R6: At a segment end with single-shot off, the follow-on start and end are copied into the current and end addresses, done is set and running stays on.
- R7: At every segment end, the shadows at indices 5 to 8 capture the current, end, follow-on start and follow-on end values held just before the end.
- R8: A write to index 0 with bit 19 set clears done and leaves the other status bits as the rest of that write sets them.
- R9: A write to index 0 with bit 20 set first clears running, single-shot, done and fault. The set bits of the same write are then applied.
- R10: A response with mem_err sets fault and stops running, gives no dev_ack, and leaves the current address unchanged. While fault is set, writes to indices 1 to 4 and the bit 16 command have no effect.
- R11: If the end address minus the current address, modulo 2^32, exceeds 8192 bytes when a transfer would start, the channel sets fault and stops running without a memory request. A span of exactly 8192 bytes is accepted.
- R12: A write to index 0 with bit 21 set copies the current, end, follow-on start and follow-on end values into the shadows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| dev_req | input | 1 | Device requests one word |
| dev_ack | output | 1 | One word moved this cycle |
| dev_wdata | input | 32 | Word from the device (device-to-memory) |
| dev_rdata | output | 32 | Word to the device (memory-to-device), valid with dev_ack |
| mem_req | output | 1 | Memory access outstanding |
| mem_we | output | 1 | Access writes memory |
| mem_addr | output | 32 | Byte address of the access |
| mem_wdata | output | 32 | Write data to memory |
| mem_rdata | input | 32 | Read data, valid with mem_rsp |
| mem_rsp | input | 1 | Memory response for the outstanding access |
| mem_err | input | 1 | Response is an error, valid with mem_rsp |

## Verification
The properties assume two things about memory. It raises mem_rsp only while mem_req is high, and it gives each access exactly one response. They also assume software does not write a pointer in the same cycle the engine moves it. The bench's memory model therefore answers only an outstanding request, after a random delay of 0 to 2 cycles. The bench writes pointers only while the channel is stopped, or while it waits with dev_req low between segments, so no register write ever meets an engine update.

// File: rtl/seg_dma_pkg.sv
// Shared register indices, command/status bit positions and engine state
// type for the chained DMA channel. Positions here are software-visible.
package seg_dma_pkg;

    typedef enum logic [3:0] {
        RIX_CSR      = 4'd0,
        RIX_NEXT     = 4'd1,
        RIX_LIMIT    = 4'd2,
        RIX_START    = 4'd3,
        RIX_STOP     = 4'd4,
        RIX_SV_NEXT  = 4'd5,
        RIX_SV_LIMIT = 4'd6,
        RIX_SV_START = 4'd7,
        RIX_SV_STOP  = 4'd8
    } reg_ix_e;

    // Command bits taken from a control write.
    localparam int CMD_SET_RUN  = 16;
    localparam int CMD_SET_ONE  = 17;
    localparam int CMD_DIR      = 18;
    localparam int CMD_CLR_DONE = 19;
    localparam int CMD_RESET    = 20;
    localparam int CMD_INIT     = 21;

    // Status bits returned on a control read.
    localparam int ST_RUN   = 24;
    localparam int ST_ONE   = 25;
    localparam int ST_DIR   = 26;
    localparam int ST_DONE  = 27;
    localparam int ST_FAULT = 28;

    typedef enum logic {
        ENG_IDLE = 1'b0,
        ENG_BUSY = 1'b1
    } eng_state_e;

    typedef struct packed {
        logic run;
        logic one_shot;
        logic dir_in;
        logic done;
        logic fault;
    } chan_status_t;

endpackage

// File: rtl/seg_dma_csr.sv
// Command decoder and status flags.
// Assumes: cmd_we is already qualified with the control-register index;
// engine events arrive as single-cycle strobes. Engine events take
// priority over the software command issued in the same cycle.
module seg_dma_csr
    import seg_dma_pkg::*;
#(
    parameter int REG_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_we,
    input  logic [REG_W-1:0] cmd_wdata,
    input  logic             ev_seg_end,
    input  logic             ev_fault,
    output chan_status_t     status,
    output logic             init_snap
);

    chan_status_t st_q;
    chan_status_t st_d;

    // Next-state of the flags: reset command, then clears, then sets, then engine events.
    always_comb begin
        st_d = st_q;
        if (cmd_we) begin
            st_d.dir_in = cmd_wdata[CMD_DIR];
            if (cmd_wdata[CMD_RESET]) begin
                st_d.run      = 1'b0;
                st_d.one_shot = 1'b0;
                st_d.done     = 1'b0;
                st_d.fault    = 1'b0;
            end
            if (cmd_wdata[CMD_CLR_DONE]) begin
                st_d.done = 1'b0;
            end
            if (cmd_wdata[CMD_SET_ONE]) begin
                st_d.one_shot = 1'b1;
            end
            if (cmd_wdata[CMD_SET_RUN] && !st_d.fault) begin
                st_d.run = 1'b1;
            end
        end
        if (ev_seg_end) begin
            st_d.done = 1'b1;
            if (st_q.one_shot) begin
                st_d.run = 1'b0;
            end
        end
        if (ev_fault) begin
            st_d.fault = 1'b1;
            st_d.run   = 1'b0;
        end
    end

    // Flag register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // Snapshot request is a plain decode of the write.
    assign init_snap = cmd_we && cmd_wdata[CMD_INIT];
    assign status    = st_q;

endmodule

// File: rtl/seg_dma_ptrs.sv
// Live pointer registers (current, end, follow-on start, follow-on end)
// and their read-only shadow copies.
// Assumes: adv and promote never occur together (engine busy vs idle);
// engine updates win over a software write in the same cycle.
module seg_dma_ptrs #(
    parameter int ADDR_W            = 32,
    parameter int WORD_BYTES        = 4,
    parameter int BEGIN_ALIGN_BYTES = 4,
    parameter int END_ALIGN_BYTES   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_we,
    input  logic [3:0]        sw_sel,
    input  logic [ADDR_W-1:0] sw_wdata,
    input  logic              frozen,
    input  logic              adv,
    input  logic              promote,
    input  logic              capture,
    output logic [ADDR_W-1:0] live   [4],
    output logic [ADDR_W-1:0] shadow [4]
);

    localparam int BEG_LSB = $clog2(BEGIN_ALIGN_BYTES);
    localparam int END_LSB = $clog2(END_ALIGN_BYTES);
    localparam logic [ADDR_W-1:0] BEG_KEEP = {ADDR_W{1'b1}} << BEG_LSB;
    localparam logic [ADDR_W-1:0] END_KEEP = {ADDR_W{1'b1}} << END_LSB;
    localparam logic [ADDR_W-1:0] STEP     = ADDR_W'(WORD_BYTES);

    logic              eng_hit [4];
    logic [ADDR_W-1:0] eng_val [4];

    // Engine-driven updates: promotion and word stepping.
    always_comb begin
        eng_hit[0] = promote || adv;
        eng_val[0] = promote ? live[2] : (live[0] + STEP);
        eng_hit[1] = promote;
        eng_val[1] = live[3];
        eng_hit[2] = 1'b0;
        eng_val[2] = live[2];
        eng_hit[3] = 1'b0;
        eng_val[3] = live[3];
    end

    genvar gi;
    generate
        for (gi = 0; gi < 4; gi++) begin : g_ptr
            // Even slots are segment starts, odd slots are segment ends.
            localparam logic [ADDR_W-1:0] KEEP = (gi % 2 == 0) ? BEG_KEEP : END_KEEP;
            logic [ADDR_W-1:0] live_q;
            logic [ADDR_W-1:0] shadow_q;

            // Live pointer: engine update, else unfrozen software write.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    live_q <= '0;
                end else if (eng_hit[gi]) begin
                    live_q <= eng_val[gi];
                end else if (sw_we && !frozen && (sw_sel == 4'(gi + 1))) begin
                    live_q <= sw_wdata & KEEP;
                end
            end

            // Shadow copy: captured on segment end or snapshot command.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    shadow_q <= '0;
                end else if (capture) begin
                    shadow_q <= live_q;
                end
            end

            assign live[gi]   = live_q;
            assign shadow[gi] = shadow_q;
        end
    endgenerate

endmodule

// File: rtl/seg_dma_engine.sv
// Transfer engine: one word per device request, segment end detection,
// span check and error capture.
// Assumes: memory answers each request exactly once with mem_rsp, and
// holds nothing across responses; pointers arrive from seg_dma_ptrs.
module seg_dma_engine
    import seg_dma_pkg::*;
#(
    parameter int ADDR_W        = 32,
    parameter int MAX_SEG_BYTES = 8192
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              fault,
    input  logic              dir_in,
    input  logic [ADDR_W-1:0] cur_next,
    input  logic [ADDR_W-1:0] cur_limit,
    input  logic              dev_req,
    input  logic              mem_rsp,
    input  logic              mem_err,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              dev_ack,
    output logic              adv,
    output logic              seg_end,
    output logic              fault_ev
);

    localparam logic [ADDR_W-1:0] MAX_SPAN = ADDR_W'(MAX_SEG_BYTES);

    eng_state_e        state_q;
    logic [ADDR_W-1:0] addr_q;
    logic              we_q;
    logic              active;
    logic              at_end;
    logic              too_long;
    logic              launch;
    logic              rsp_ok;
    logic              rsp_bad;
    logic [ADDR_W-1:0] span;

    // Decode of what the engine does this cycle.
    always_comb begin
        span     = cur_limit - cur_next;
        active   = (state_q == ENG_IDLE) && run && !fault;
        at_end   = (cur_next == cur_limit);
        too_long = (span > MAX_SPAN);
        seg_end  = active && at_end;
        launch   = active && !at_end && !too_long && dev_req;
        rsp_ok   = (state_q == ENG_BUSY) && mem_rsp && !mem_err;
        rsp_bad  = (state_q == ENG_BUSY) && mem_rsp && mem_err;
        fault_ev = rsp_bad || (active && !at_end && too_long);
        adv      = rsp_ok;
        dev_ack  = rsp_ok;
    end

    // Request state, address and direction latched at launch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ENG_IDLE;
            addr_q  <= '0;
            we_q    <= 1'b0;
        end else begin
            case (state_q)
                ENG_IDLE: begin
                    if (launch) begin
                        state_q <= ENG_BUSY;
                        addr_q  <= cur_next;
                        we_q    <= dir_in;
                    end
                end
                ENG_BUSY: begin
                    if (mem_rsp) begin
                        state_q <= ENG_IDLE;
                    end
                end
                default: state_q <= ENG_IDLE;
            endcase
        end
    end

    assign mem_req  = (state_q == ENG_BUSY);
    assign mem_we   = we_q;
    assign mem_addr = addr_q;

endmodule

// File: rtl/seg_dma_channel.sv
// Top of the chained double-buffer DMA channel: register port decode,
// read mux and wiring of flags, pointers and engine.
// Assumes: register reads are combinational on reg_addr; data words are
// passed straight between device and memory ports.
module seg_dma_channel
    import seg_dma_pkg::*;
#(
    parameter int ADDR_W            = 32,
    parameter int DATA_W            = 32,
    parameter int MAX_SEG_BYTES     = 8192,
    parameter int BEGIN_ALIGN_BYTES = 4,
    parameter int END_ALIGN_BYTES   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [3:0]        reg_addr,
    input  logic [ADDR_W-1:0] reg_wdata,
    output logic [ADDR_W-1:0] reg_rdata,
    input  logic              dev_req,
    output logic              dev_ack,
    input  logic [DATA_W-1:0] dev_wdata,
    output logic [DATA_W-1:0] dev_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_rsp,
    input  logic              mem_err
);

    localparam int WORD_BYTES = DATA_W / 8;

    chan_status_t      status;
    logic              init_snap;
    logic              ev_adv;
    logic              ev_seg_end;
    logic              ev_fault;
    logic              promote;
    logic              csr_we;
    logic [ADDR_W-1:0] live   [4];
    logic [ADDR_W-1:0] shadow [4];
    logic [ADDR_W-1:0] status_word;

    // Names used by the bound checker.
    logic              st_run;
    logic              st_one;
    logic              st_done;
    logic              st_fault;
    logic [ADDR_W-1:0] cur_next;
    logic [ADDR_W-1:0] cur_limit;

    assign csr_we  = reg_we && (reg_addr == 4'(RIX_CSR));
    assign promote = ev_seg_end && !status.one_shot;

    seg_dma_csr #(
        .REG_W (ADDR_W)
    ) u_csr (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_we     (csr_we),
        .cmd_wdata  (reg_wdata),
        .ev_seg_end (ev_seg_end),
        .ev_fault   (ev_fault),
        .status     (status),
        .init_snap  (init_snap)
    );

    seg_dma_ptrs #(
        .ADDR_W            (ADDR_W),
        .WORD_BYTES        (WORD_BYTES),
        .BEGIN_ALIGN_BYTES (BEGIN_ALIGN_BYTES),
        .END_ALIGN_BYTES   (END_ALIGN_BYTES)
    ) u_ptrs (
        .clk      (clk),
        .rst_n    (rst_n),
        .sw_we    (reg_we),
        .sw_sel   (reg_addr),
        .sw_wdata (reg_wdata),
        .frozen   (status.fault),
        .adv      (ev_adv),
        .promote  (promote),
        .capture  (ev_seg_end || init_snap),
        .live     (live),
        .shadow   (shadow)
    );

    seg_dma_engine #(
        .ADDR_W        (ADDR_W),
        .MAX_SEG_BYTES (MAX_SEG_BYTES)
    ) u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (status.run),
        .fault     (status.fault),
        .dir_in    (status.dir_in),
        .cur_next  (live[0]),
        .cur_limit (live[1]),
        .dev_req   (dev_req),
        .mem_rsp   (mem_rsp),
        .mem_err   (mem_err),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .dev_ack   (dev_ack),
        .adv       (ev_adv),
        .seg_end   (ev_seg_end),
        .fault_ev  (ev_fault)
    );

    // Data passes straight through between the two ports.
    assign mem_wdata = dev_wdata;
    assign dev_rdata = mem_rdata;

    // Status word assembly.
    always_comb begin
        status_word           = '0;
        status_word[ST_RUN]   = status.run;
        status_word[ST_ONE]   = status.one_shot;
        status_word[ST_DIR]   = status.dir_in;
        status_word[ST_DONE]  = status.done;
        status_word[ST_FAULT] = status.fault;
    end

    // Register read mux.
    always_comb begin
        case (reg_addr)
            4'(RIX_CSR):      reg_rdata = status_word;
            4'(RIX_NEXT):     reg_rdata = live[0];
            4'(RIX_LIMIT):    reg_rdata = live[1];
            4'(RIX_START):    reg_rdata = live[2];
            4'(RIX_STOP):     reg_rdata = live[3];
            4'(RIX_SV_NEXT):  reg_rdata = shadow[0];
            4'(RIX_SV_LIMIT): reg_rdata = shadow[1];
            4'(RIX_SV_START): reg_rdata = shadow[2];
            4'(RIX_SV_STOP):  reg_rdata = shadow[3];
            default:          reg_rdata = '0;
        endcase
    end

    assign st_run    = status.run;
    assign st_one    = status.one_shot;
    assign st_done   = status.done;
    assign st_fault  = status.fault;
    assign cur_next  = live[0];
    assign cur_limit = live[1];

endmodule

// File: rtl/seg_dma_channel_chk.sv
// Protocol and state checks for seg_dma_channel, attached by bind.
// Assumes: memory responds only to an outstanding request.
module seg_dma_channel_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_we,
    input logic              mem_req,
    input logic              mem_rsp,
    input logic              mem_err,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              dev_ack,
    input logic              st_run,
    input logic              st_one,
    input logic              st_done,
    input logic              st_fault,
    input logic [ADDR_W-1:0] cur_next,
    input logic [ADDR_W-1:0] cur_limit
);

    // R5: an unanswered request keeps its address.
    a_r5_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_rsp) |=> (mem_req && $stable(mem_addr)));

    // R5: a good response steps the current address by one word.
    a_r5_step: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_rsp && !mem_err && !reg_we) |=> (cur_next == $past(cur_next) + 4));

    // R5: device acknowledge only with a good memory response.
    a_r5_ack_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        dev_ack |-> (mem_req && mem_rsp && !mem_err));

    // R4: single-shot segment end stops the channel and flags done.
    a_r4_last_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (st_run && st_one && !st_fault && !mem_req && (cur_next == cur_limit) && !reg_we)
        |=> (!st_run && st_done));

    // R10: an error response halts and keeps the address.
    a_r10_err_halts: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_rsp && mem_err && !reg_we)
        |=> (st_fault && !st_run && (cur_next == $past(cur_next))));

    // R10: no memory traffic while faulted.
    a_r10_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        st_fault |-> !mem_req);

endmodule

bind seg_dma_channel seg_dma_channel_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .mem_req   (mem_req),
    .mem_rsp   (mem_rsp),
    .mem_err   (mem_err),
    .mem_addr  (mem_addr),
    .dev_ack   (dev_ack),
    .st_run    (st_run),
    .st_one    (st_one),
    .st_done   (st_done),
    .st_fault  (st_fault),
    .cur_next  (cur_next),
    .cur_limit (cur_limit)
);

// File: tb/seg_dma_channel_test.sv
`timescale 1ns/1ps
module seg_dma_channel_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = 4'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic        dev_req;
    logic        dev_ack;
    logic [31:0] dev_wdata = 32'hD000_0000;
    logic [31:0] dev_rdata;
    logic        mem_req;
    logic        mem_we;
    logic [31:0] mem_addr;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata = 32'd0;
    logic        mem_rsp = 1'b0;
    logic        mem_err = 1'b0;

    int          tests = 0;
    int          fails = 0;
    int          words_left = 0;
    int          xfers = 0;
    int          req_seen = 0;
    logic [31:0] exp_addr = 32'd0;
    logic        exp_we = 1'b0;
    logic [31:0] dev_pat = 32'hD000_0000;
    logic        err_en = 1'b0;
    logic [31:0] err_addr = 32'd0;
    logic [31:0] mem_model [0:1023];
    logic        finished = 1'b0;

    assign dev_req = (words_left > 0);

    always #2 clk = ~clk;

    seg_dma_channel uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .dev_req   (dev_req),
        .dev_ack   (dev_ack),
        .dev_wdata (dev_wdata),
        .dev_rdata (dev_rdata),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .mem_rsp   (mem_rsp),
        .mem_err   (mem_err)
    );

    function automatic logic [31:0] fill_word(input int idx);
        return 32'h5A5A_0000 ^ (32'(idx) * 32'd3);
    endfunction

    function automatic logic [31:0] st_word(input bit run, input bit one,
                                            input bit dir, input bit done,
                                            input bit flt);
        return {3'b0, flt, done, dir, one, run, 24'd0};
    endfunction

    task automatic check_eq(input string req, input logic [31:0] act,
                            input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr  = a;
        reg_wdata = d;
        reg_we    = 1'b1;
        @(negedge clk);
        reg_we    = 1'b0;
    endtask

    task automatic reg_read(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic expect_reg(input string req, input logic [3:0] a,
                              input logic [31:0] exp);
        logic [31:0] v;
        reg_read(a, v);
        check_eq(req, v, exp);
    endtask

    task automatic run_words(input int n);
        int guard;
        guard = 0;
        @(negedge clk);
        words_left = n;
        while (words_left > 0 && guard < 2000) begin
            @(negedge clk);
            guard++;
        end
        repeat (5) @(negedge clk);
    endtask

    // Memory and device model: answers outstanding requests after 0..2 cycles.
    initial begin
        int lat;
        int idx;
        lat = 0;
        for (int i = 0; i < 1024; i++) mem_model[i] = fill_word(i);
        forever begin
            @(negedge clk);
            if (mem_req) req_seen++;
            if (mem_rsp) begin
                mem_rsp = 1'b0;
                mem_err = 1'b0;
            end else if (mem_req && rst_n) begin
                if (lat > 0) begin
                    lat--;
                end else begin
                    lat = int'($urandom % 3);
                    idx = int'(mem_addr[11:2]);
                    xfers++;
                    check_eq("R5 address", mem_addr, exp_addr);
                    check_eq("R5 direction", 32'(mem_we), 32'(exp_we));
                    exp_addr = exp_addr + 32'd4;
                    if (err_en && mem_addr == err_addr) begin
                        mem_err = 1'b1;
                        mem_rsp = 1'b1;
                        words_left = 0;
                        #1;
                        check_eq("R10 no ack on error", 32'(dev_ack), 32'd0);
                    end else begin
                        if (mem_we) begin
                            check_eq("R5 write data", mem_wdata, dev_pat);
                            mem_model[idx] = mem_wdata;
                        end
                        mem_rdata = mem_model[idx];
                        mem_rsp = 1'b1;
                        #1;
                        check_eq("R5 ack", 32'(dev_ack), 32'd1);
                        if (!mem_we) check_eq("R5 read data", dev_rdata, mem_model[idx]);
                        dev_pat = dev_pat + 32'd1;
                        dev_wdata = dev_pat;
                        words_left--;
                    end
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state.
        expect_reg("R1 csr", 4'd0, 32'd0);
        for (int i = 1; i <= 8; i++) expect_reg("R1 pointer", 4'(i), 32'd0);
        check_eq("R1 mem_req", 32'(mem_req), 32'd0);
        check_eq("R1 dev_ack", 32'(dev_ack), 32'd0);

        // R2: command bits and status layout.
        reg_write(4'd0, 32'h0006_0000);
        expect_reg("R2 set one-shot+dir", 4'd0, st_word(0, 1, 1, 0, 0));
        reg_write(4'd0, 32'h0000_0000);
        expect_reg("R2 dir follows bit18", 4'd0, st_word(0, 1, 0, 0, 0));
        reg_write(4'd0, 32'h0010_0000);

        // R3: alignment and read-only shadows.
        reg_write(4'd1, 32'h0000_1003);
        expect_reg("R3 next align", 4'd1, 32'h0000_1000);
        reg_write(4'd2, 32'h0000_1237);
        expect_reg("R3 limit align", 4'd2, 32'h0000_1230);
        reg_write(4'd3, 32'h0000_0ABE);
        expect_reg("R3 start align", 4'd3, 32'h0000_0ABC);
        reg_write(4'd4, 32'h0000_0AFF);
        expect_reg("R3 stop align", 4'd4, 32'h0000_0AF0);
        reg_write(4'd5, 32'h1234_5670);
        expect_reg("R3 shadow read-only", 4'd5, 32'd0);

        // R4: empty segment ends without any transfer.
        begin
            int x0;
            x0 = xfers;
            reg_write(4'd1, 32'h200);
            reg_write(4'd2, 32'h200);
            reg_write(4'd0, 32'h0013_0000);
            repeat (4) @(negedge clk);
            expect_reg("R4 empty segment", 4'd0, st_word(0, 1, 0, 1, 0));
            check_eq("R4 no transfer", 32'(xfers - x0), 32'd0);
            reg_write(4'd0, 32'h0010_0000);
        end

        // R4/R5: random single-shot segments in both directions.
        for (int it = 0; it < 8; it++) begin
            logic [31:0] base;
            logic [31:0] nxt;
            logic [31:0] lim;
            logic        dir;
            int          n;
            int          x0;
            dir  = 1'($urandom % 2);
            base = ($urandom % 32'hC0) << 4;
            nxt  = base + (($urandom % 4) << 2);
            lim  = base + ((($urandom % 4) + 1) << 4);
            n    = int'((lim - nxt) >> 2);
            x0   = xfers;
            exp_addr = nxt;
            exp_we   = dir;
            reg_write(4'd1, nxt);
            reg_write(4'd2, lim);
            reg_write(4'd0, 32'h0013_0000 | (32'(dir) << 18));
            run_words(n);
            check_eq("R5 word count", 32'(xfers - x0), 32'(n));
            expect_reg("R4 single-shot end", 4'd0, st_word(0, 1, dir, 1, 0));
            expect_reg("R5 next reaches limit", 4'd1, lim);
            reg_write(4'd0, 32'h0010_0000);
        end

        // R6/R7/R8: chained segments, device-to-memory.
        reg_write(4'd1, 32'h300);
        reg_write(4'd2, 32'h320);
        reg_write(4'd3, 32'h400);
        reg_write(4'd4, 32'h410);
        exp_addr = 32'h300;
        exp_we   = 1'b1;
        reg_write(4'd0, 32'h0015_0000);
        run_words(8);
        expect_reg("R6 keeps running", 4'd0, st_word(1, 0, 1, 1, 0));
        expect_reg("R6 next promoted", 4'd1, 32'h400);
        expect_reg("R6 limit promoted", 4'd2, 32'h410);
        expect_reg("R7 shadow next", 4'd5, 32'h320);
        expect_reg("R7 shadow limit", 4'd6, 32'h320);
        expect_reg("R7 shadow start", 4'd7, 32'h400);
        expect_reg("R7 shadow stop", 4'd8, 32'h410);
        reg_write(4'd0, 32'h000E_0000);
        expect_reg("R8 clear done", 4'd0, st_word(1, 1, 1, 0, 0));
        exp_addr = 32'h400;
        run_words(4);
        expect_reg("R4 second segment stops", 4'd0, st_word(0, 1, 1, 1, 0));
        expect_reg("R7 shadow next again", 4'd5, 32'h410);
        expect_reg("R7 shadow start again", 4'd7, 32'h400);
        check_eq("R6 memory written", mem_model[(32'h40C) >> 2], dev_pat - 32'd1);
        reg_write(4'd0, 32'h0010_0000);

        // R10/R9: bus error capture, freeze, and reset command.
        err_en   = 1'b1;
        err_addr = 32'h60C;
        reg_write(4'd1, 32'h600);
        reg_write(4'd2, 32'h640);
        exp_addr = 32'h600;
        exp_we   = 1'b0;
        reg_write(4'd0, 32'h0013_0000);
        run_words(16);
        expect_reg("R10 fault status", 4'd0, st_word(0, 1, 0, 0, 1));
        expect_reg("R10 next frozen", 4'd1, 32'h60C);
        reg_write(4'd1, 32'h700);
        expect_reg("R10 pointer write ignored", 4'd1, 32'h60C);
        reg_write(4'd0, 32'h0001_0000);
        expect_reg("R10 set-run ignored", 4'd0, st_word(0, 1, 0, 0, 1));
        reg_write(4'd0, 32'h0010_0000);
        expect_reg("R9 reset clears flags", 4'd0, 32'd0);
        reg_write(4'd1, 32'h700);
        expect_reg("R9 pointers writable again", 4'd1, 32'h700);
        err_en = 1'b0;

        // R11: oversize span faults without a request; exact limit runs.
        begin
            int r0;
            reg_write(4'd1, 32'h0);
            reg_write(4'd2, 32'h4000);
            r0 = req_seen;
            reg_write(4'd0, 32'h0013_0000);
            repeat (4) @(negedge clk);
            expect_reg("R11 oversize fault", 4'd0, st_word(0, 1, 0, 0, 1));
            check_eq("R11 no request", 32'(req_seen - r0), 32'd0);
            reg_write(4'd0, 32'h0010_0000);
            reg_write(4'd2, 32'h2000);
            reg_write(4'd0, 32'h0013_0000);
            repeat (4) @(negedge clk);
            expect_reg("R11 exact span accepted", 4'd0, st_word(1, 1, 0, 0, 0));
            reg_write(4'd0, 32'h0010_0000);
        end

        // R12: snapshot command copies live pointers into shadows.
        reg_write(4'd1, 32'h100);
        reg_write(4'd2, 32'h110);
        reg_write(4'd3, 32'h120);
        reg_write(4'd4, 32'h130);
        reg_write(4'd0, 32'h0020_0000);
        expect_reg("R12 shadow next", 4'd5, 32'h100);
        expect_reg("R12 shadow limit", 4'd6, 32'h110);
        expect_reg("R12 shadow start", 4'd7, 32'h120);
        expect_reg("R12 shadow stop", 4'd8, 32'h130);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule